// File: doc/BRIEF.md
# Receive Descriptor Status Writeback Engine

This block sits beside a receive DMA and takes care of the status word in each receive descriptor while a frame is stored across one or more data buffers of up to 2 KiB each. An upstream list walker supplies the address of the descriptor in use. A progress event then says either that this descriptor's buffer is full and the frame goes on, or that the frame has ended.

A full buffer is handed back to software straight away. The block writes a release word with the ownership bit clear, so software can work on the buffer while the rest of the frame is still arriving. When the frame ends, the block builds one status word that holds the completion flag, the frame byte count and the error type. It writes that word to the last descriptor, and also to the first descriptor of the frame if the two are different. Software can then read the frame result from whichever end it reaches first.

Memory writes go out on a simple request port. The address and data stay fixed until the ready input is seen.

Top module: `rx_status_wb`

## Requirements
- R1: A buffer-full event without frame end causes exactly one write, to that event's descriptor address. The data has bit 31 (owner) = 0, bit 30 (complete) = 0, bit 28 = 0, and all other bits 0 except bit 29. Bit 29 (first) is 1 only when the descriptor opens a new frame.
- R2: A frame-end event in a frame that already released descriptors causes two writes of one identical word. The first goes to the address latched with the frame's first descriptor, and the second goes to the ending descriptor's address, in that order.
- R3: A frame-end event with no earlier descriptor in the frame causes exactly one write, to that event's descriptor address.
- R4: The end-of-frame word is laid out as follows. Bit 31 = 0 and bits 30, 29 and 28 = 1. Bit 27 = 1 when the error code is nonzero. Bits 26:16 hold the 11-bit byte count, bits 2:0 hold the 3-bit error code, and bits 15:3 are 0.
- R5: While `mem_req_o` is high and `mem_ready_i` is low, `mem_req_o`, `mem_addr_o` and `mem_data_o` hold their values.
- R6: `ev_ready_o` is low whenever a write is outstanding. Events are taken only while it is high.
- R7: An accepted event with neither flag set causes no write and leaves the open frame and its first address unchanged.
- R8: An event with both buffer-full and frame-end set is handled as a frame end.
- R9: After reset, no write is requested, `ev_ready_o` is high and no frame is open.
- R10: After a frame-end event, the next buffer-full event opens a new frame (first bit set, new first address).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_valid_i | input | 1 | Progress event present |
| ev_ready_o | output | 1 | Event accepted this cycle when high together with valid |
| ev_buf_full_i | input | 1 | Current descriptor's buffer is used up |
| ev_end_i | input | 1 | Frame ends in the current descriptor |
| ev_count_i | input | 11 | Frame byte count (used on frame end) |
| ev_err_i | input | 3 | Receive error type, 0 = none (used on frame end) |
| desc_addr_i | input | ADDR_W | Address of the descriptor the event refers to |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | ADDR_W | Write address (status word of a descriptor) |
| mem_data_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Write accepted |

## Verification
The hardest case is an end-of-frame pair whose writes stall. The second write must reuse the exact word of the first while the address switches from the latched first descriptor to the ending one. A neutral event arriving mid-frame must not disturb the latched address either. The stimulus opens a multi-descriptor frame and inserts an event with no flag set. It then ends the frame while the bench's ready generator holds the bus off for several cycles on each write, and meanwhile checks that the port does not move and that new events are refused.

// File: rtl/rx_wb_pkg.sv
package rx_wb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 11;
  localparam int unsigned ERR_W  = 3;
  localparam int unsigned RSV_W  = WORD_W - 5 - CNT_W - ERR_W;

  typedef struct packed {
    logic             own;
    logic             done;
    logic             first;
    logic             last;
    logic             err_any;
    logic [CNT_W-1:0] cnt;
    logic [RSV_W-1:0] rsv;
    logic [ERR_W-1:0] err;
  } stat_word_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2
  } wb_state_e;
endpackage

// File: rtl/rx_wb_fmt.sv
module rx_wb_fmt
  import rx_wb_pkg::*;
(
  input  logic             fin_i,
  input  logic             opens_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [ERR_W-1:0] err_i,
  output stat_word_t       word_o
);
  always_comb begin
    word_o         = '0;
    word_o.own     = 1'b0;
    word_o.done    = fin_i;
    word_o.first   = fin_i | opens_i;
    word_o.last    = fin_i;
    word_o.err_any = fin_i & (|err_i);
    word_o.cnt     = fin_i ? cnt_i : '0;
    word_o.err     = fin_i ? err_i : '0;
  end
endmodule

// File: rtl/rx_wb_track.sv
module rx_wb_track #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_full_i,
  input  logic              take_end_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              open_o,
  output logic [ADDR_W-1:0] first_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o       <= 1'b0;
      first_addr_o <= '0;
    end else if (take_end_i) begin
      open_o <= 1'b0;
    end else if (take_full_i && !open_o) begin
      open_o       <= 1'b1;
      first_addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/rx_status_wb.sv
module rx_status_wb
  import rx_wb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  output logic              ev_ready_o,
  input  logic              ev_buf_full_i,
  input  logic              ev_end_i,
  input  logic [10:0]       ev_count_i,
  input  logic [2:0]        ev_err_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_data_o,
  input  logic              mem_ready_i
);
  wb_state_e         state_q;
  logic [ADDR_W-1:0] wr_addr_q, nxt_addr_q, first_addr;
  stat_word_t        wr_word_q, new_word;
  logic              open_frame, take, take_end, take_full;

  assign ev_ready_o = (state_q == ST_IDLE);
  assign take       = ev_valid_i & ev_ready_o;
  assign take_end   = take & ev_end_i;
  assign take_full  = take & ev_buf_full_i & ~ev_end_i;

  rx_wb_track #(.ADDR_W(ADDR_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_full_i (take_full),
    .take_end_i  (take_end),
    .addr_i      (desc_addr_i),
    .open_o      (open_frame),
    .first_addr_o(first_addr)
  );

  rx_wb_fmt u_fmt (
    .fin_i  (ev_end_i),
    .opens_i(~open_frame),
    .cnt_i  (ev_count_i),
    .err_i  (ev_err_i),
    .word_o (new_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wr_addr_q  <= '0;
      nxt_addr_q <= '0;
      wr_word_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_end || take_full) wr_word_q <= new_word;
          if (take_end && open_frame) begin
            wr_addr_q  <= first_addr;
            nxt_addr_q <= desc_addr_i;
            state_q    <= ST_TWO;
          end else if (take_end || take_full) begin
            wr_addr_q <= desc_addr_i;
            state_q   <= ST_ONE;
          end
        end
        ST_TWO: if (mem_ready_i) begin
          wr_addr_q <= nxt_addr_q;
          state_q   <= ST_ONE;
        end
        ST_ONE: if (mem_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q != ST_IDLE);
  assign mem_addr_o = wr_addr_q;
  assign mem_data_o = wr_word_q;
endmodule

// File: rtl/rx_wb_chk.sv
module rx_wb_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ev_ready_o,
  input logic              mem_req_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_data_o
);
  a_r5_hold_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o));

  a_r6_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ev_ready_o);

  a_r4_owner_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !mem_data_o[31]);

  a_r1_release_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_data_o[30] |-> mem_data_o[28:0] == 29'd0);

  a_r2_same_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i && mem_data_o[30] |=> !mem_req_o || $stable(mem_data_o));
endmodule

bind rx_status_wb rx_wb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ev_ready_o (ev_ready_o),
  .mem_req_o  (mem_req_o),
  .mem_ready_i(mem_ready_i),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o)
);

// File: tb/rx_status_wb_tb.sv
`timescale 1ns/1ps
module rx_status_wb_tb;
  localparam int AW = 32;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ev_valid_i = 0, ev_buf_full_i = 0, ev_end_i = 0, mem_ready_i = 0;
  logic [10:0] ev_count_i = '0;
  logic [2:0] ev_err_i = '0;
  logic [AW-1:0] desc_addr_i = '0;
  logic ev_ready_o, mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_data_o;

  int tests = 0, fails = 0, stall_n = 0, wcnt = 0, hold_err = 0, stall_seen = 0;
  int log_n = 0;
  logic [31:0] log_a [16];
  logic [31:0] log_d [16];
  logic pend = 0;
  logic [31:0] pa, pd;

  always #2 clk_i = ~clk_i;

  rx_status_wb #(.ADDR_W(AW)) u_dut (.*);

  // ready generator with configurable stall
  always @(negedge clk_i) begin
    if (mem_ready_i) begin
      mem_ready_i = 1'b0;
      wcnt = 0;
    end else if (mem_req_o) begin
      if (wcnt >= stall_n) mem_ready_i = 1'b1;
      else wcnt++;
    end
  end

  // write log and hold monitor
  always @(posedge clk_i) begin
    if (pend && (mem_addr_o != pa || mem_data_o != pd || !mem_req_o)) hold_err++;
    pend = mem_req_o && !mem_ready_i;
    if (pend) stall_seen++;
    pa = mem_addr_o;
    pd = mem_data_o;
    if (mem_req_o && mem_ready_i && log_n < 16) begin
      log_a[log_n] = mem_addr_o;
      log_d[log_n] = mem_data_o;
      log_n++;
    end
  end

  function automatic logic [31:0] fin_w(logic [10:0] c, logic [2:0] e);
    return {1'b0, 1'b1, 1'b1, 1'b1, (e != 0), c, 13'd0, e};
  endfunction
  function automatic logic [31:0] rel_w(bit first);
    return {2'b00, first, 29'd0};
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk_wr(int i, string rq, logic [31:0] a, logic [31:0] d);
    chk(log_a[i] == a, rq, log_a[i], a);
    chk(log_d[i] == d, rq, log_d[i], d);
  endtask

  task automatic send_ev(bit full, bit fin, logic [31:0] a, logic [10:0] c, logic [2:0] e);
    @(negedge clk_i);
    ev_valid_i = 1; ev_buf_full_i = full; ev_end_i = fin;
    desc_addr_i = a; ev_count_i = c; ev_err_i = e;
    while (!ev_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    ev_valid_i = 0; ev_buf_full_i = 0; ev_end_i = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (mem_req_o || !ev_ready_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk(mem_req_o == 0, "R9", 32'(mem_req_o), 0);
    chk(ev_ready_o == 1, "R9", 32'(ev_ready_o), 1);
  endtask

  task automatic t_single();
    log_n = 0;
    send_ev(0, 1, 32'h100, 11'd100, 3'd0);
    wait_idle();
    chk(log_n == 1, "R3", log_n, 1);
    chk_wr(0, "R3_R4", 32'h100, fin_w(11'd100, 3'd0));
  endtask

  task automatic t_multi();
    log_n = 0;
    send_ev(1, 0, 32'h200, 11'd0, 3'd0);
    send_ev(1, 0, 32'h210, 11'd0, 3'd0);
    send_ev(0, 1, 32'h220, 11'd1500, 3'd0);
    wait_idle();
    chk(log_n == 4, "R2", log_n, 4);
    chk_wr(0, "R1_R9", 32'h200, rel_w(1));
    chk_wr(1, "R1", 32'h210, rel_w(0));
    chk_wr(2, "R2", 32'h200, fin_w(11'd1500, 3'd0));
    chk_wr(3, "R2", 32'h220, fin_w(11'd1500, 3'd0));
  endtask

  task automatic t_stall_null();
    int n0;
    log_n = 0; stall_n = 3; hold_err = 0; stall_seen = 0;
    send_ev(1, 0, 32'h300, 11'd0, 3'd0);
    wait_idle();
    n0 = log_n;
    send_ev(0, 0, 32'h3F0, 11'd7, 3'd1);   // neutral event
    repeat (3) @(negedge clk_i);
    chk(log_n == n0, "R7", log_n, n0);
    chk(mem_req_o == 0, "R7", 32'(mem_req_o), 0);
    send_ev(0, 1, 32'h310, 11'd2047, 3'd5);
    chk(mem_req_o == 1 && ev_ready_o == 0, "R6", 32'(ev_ready_o), 0);
    wait_idle();
    chk(log_n == 3, "R7", log_n, 3);
    chk_wr(1, "R7_R2", 32'h300, fin_w(11'd2047, 3'd5));
    chk_wr(2, "R2_R4", 32'h310, fin_w(11'd2047, 3'd5));
    chk(hold_err == 0, "R5", hold_err, 0);
    chk(stall_seen > 0, "R5", stall_seen, 1);
    stall_n = 0;
  endtask

  task automatic t_both_flags();
    log_n = 0;
    send_ev(1, 0, 32'h400, 11'd0, 3'd0);
    send_ev(1, 1, 32'h410, 11'd64, 3'd2);
    wait_idle();
    chk(log_n == 3, "R8", log_n, 3);
    chk_wr(1, "R8", 32'h400, fin_w(11'd64, 3'd2));
    chk_wr(2, "R8", 32'h410, fin_w(11'd64, 3'd2));
  endtask

  task automatic t_next_frame();
    log_n = 0;
    send_ev(1, 0, 32'h500, 11'd0, 3'd0);
    send_ev(0, 1, 32'h510, 11'd900, 3'd0);
    send_ev(1, 0, 32'h600, 11'd0, 3'd0);
    send_ev(0, 1, 32'h610, 11'd33, 3'd0);
    wait_idle();
    chk(log_n == 6, "R10", log_n, 6);
    chk_wr(3, "R10", 32'h600, rel_w(1));
    chk_wr(4, "R10", 32'h600, fin_w(11'd33, 3'd0));
    chk_wr(5, "R10", 32'h610, fin_w(11'd33, 3'd0));
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_multi();
    t_single();
    t_stall_null();
    t_both_flags();
    t_next_frame();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule